// File: doc/BRIEF.md
# GPIO Pad Controller with Edge and Level Interrupts

This block manages a parameterised bank of general-purpose pads, 28 by default, from a plain 32-bit register bus with address, write enable, write data and combinational read data. Each pad owns a 16-byte register window. That window holds a configuration word, an auxiliary configuration word, a value word and a debug scratch word. The configuration word selects the pad function, the interrupt trigger and open-drain output. Pull strength and pull assignment bits are stored and read back only. The value word holds the active-low input and output enables and the pad level.

Every pad input is resynchronised through two flops. It is then compared against its previous synchronised value to find rising and falling edges, or checked directly against a level. A detected event sets a sticky status bit. The status bits are grouped into 32-bit words at a separate offset, and software clears them by writing ones. One interrupt line is the OR of all status bits. The interrupt handler reads the banked status words and clears what it has serviced.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, every configuration, auxiliary and debug word reads 0, every value word reads 0x6 (both enables disabled), every status word reads 0, `irq` is low and no pad is driven.
- R2: Pad n's window starts at byte address n*16. Offset +0x0 is the configuration word, +0x4 the auxiliary word, +0x8 the value word and +0xC the debug word. Configuration, auxiliary and debug keep all 32 bits. The value word keeps bits 2:0 and reads 0 above them. Windows of pads at or above the pad count read 0.
- R3: Trigger code 3'b010 in configuration bits [26:24] (bit 26 falling/low, bit 25 rising/high, bit 24 level) detects rising edges. The status bit and `irq` rise on the third clock edge after the pad input rises.
- R4: Trigger code 3'b100 detects falling edges.
- R5: Trigger code 3'b110 detects both edges.
- R6: Trigger code 3'b011 is active-high level. The status bit is set again on every cycle the synchronised input is high, so a clear takes effect only once the input is low.
- R7: Trigger code 3'b101 is active-low level, with the same re-set behaviour while the input is low.
- R8: A pad sets no status bit in any of these cases: all three trigger bits are clear; its mux field (bits 2:0) differs from its GPIO mux value, which is 1 for pads flagged in `ALT_MUX_PADS` (pads 24 and 25 by default) and 0 otherwise; or the direct-route bit 27 is set.
- R9: Pad n's status is bit n mod 32 of the word at 0x800 + 4*(n/32). Status bits are sticky. Writing 1 to a bit clears it and writing 0 has no effect. Bits for pads at or above the pad count read 0.
- R10: `irq` is high exactly when some status bit is set.
- R11: With value bit 1 at 0, the pad drives value bit 0. With configuration bit 31 (open-drain) also set, the pad is driven only while bit 0 is 0 and is released otherwise.
- R12: While value bit 2 (input enable, active low) is 0, a read of value bit 0 returns the synchronised pad input. Otherwise it returns the stored level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_out | output | NUM_PADS | Level driven onto each pad |
| pad_oe | output | NUM_PADS | Drive enable for each pad |
| irq | output | 1 | OR of all interrupt status bits |

## Verification
A corrupted trigger decode or a stale edge-history flop shows up at the ports as a status bit and `irq` that are set when they should not be, or missing when they should be. This is visible three clock edges after the pad input changes. A broken clear path shows as a status word that still reads as set on the read right after the clearing write, or one that reads as cleared while a level is still asserted. A wrong window or bank decode surfaces at once, because a read returns another register's contents. Pad drive errors appear on `pad_oe` and `pad_out` in the cycle after the value or configuration write.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int WORD_W    = 32;
    localparam int WIN_SHIFT = 4;
    localparam int STAT_BASE = 'h800;
    localparam int BANK_W    = 32;
    localparam int MUX_W     = 3;

    localparam int OD_BIT    = 31;
    localparam int DIRQ_BIT  = 27;
    localparam int TRIG_LO   = 24;

    localparam int VAL_W     = 3;
    localparam logic [VAL_W-1:0] VAL_RST = 3'b110;

    typedef enum logic [1:0] {
        SEL_CFG = 2'd0,
        SEL_AUX = 2'd1,
        SEL_VAL = 2'd2,
        SEL_DBG = 2'd3
    } regsel_e;

    typedef struct packed {
        logic neg;
        logic pos;
        logic lvl;
    } trig_t;

    typedef struct packed {
        logic             od;
        logic             dirq;
        trig_t            trig;
        logic [MUX_W-1:0] mux;
    } cfg_view_t;

    typedef struct packed {
        logic in_dis;
        logic out_dis;
        logic level;
    } val_t;

    function automatic cfg_view_t cfg_view(input logic [WORD_W-1:0] w);
        cfg_view_t v;
        v.od   = w[OD_BIT];
        v.dirq = w[DIRQ_BIT];
        v.trig = trig_t'(w[TRIG_LO +: 3]);
        v.mux  = w[MUX_W-1:0];
        return v;
    endfunction

    function automatic logic trig_hit(input trig_t t, input logic cur, input logic prv);
        if (t.lvl)
            return (t.pos & cur) | (t.neg & ~cur);
        return (t.pos & cur & ~prv) | (t.neg & ~cur & prv);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad
    import gpio_pad_pkg::*;
#(
    parameter logic [MUX_W-1:0] GPIO_MUX = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  regsel_e           sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              stat_clr,
    input  logic              pin_s,
    output logic [WORD_W-1:0] rd_word,
    output logic              status,
    output logic              armed,
    output logic              od,
    output logic              pad_out,
    output logic              pad_oe
);
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] aux_q;
    logic [WORD_W-1:0] dbg_q;
    val_t              val_q;
    logic              prev_q;
    logic              status_q;

    cfg_view_t view;
    logic      eligible;
    logic      hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            aux_q <= '0;
            dbg_q <= '0;
            val_q <= val_t'(VAL_RST);
        end else if (wr_hit) begin
            unique case (sel)
                SEL_CFG: cfg_q <= wdata;
                SEL_AUX: aux_q <= wdata;
                SEL_VAL: val_q <= val_t'(wdata[VAL_W-1:0]);
                SEL_DBG: dbg_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        view     = cfg_view(cfg_q);
        eligible = (view.mux == GPIO_MUX) && !view.dirq;
        armed    = eligible && (view.trig != '0);
        hit      = eligible && trig_hit(view.trig, pin_s, prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            status_q <= 1'b0;
        end else begin
            prev_q   <= pin_s;
            status_q <= hit | (status_q & ~stat_clr);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CFG: rd_word = cfg_q;
            SEL_AUX: rd_word = aux_q;
            SEL_VAL: rd_word = {{(WORD_W-VAL_W){1'b0}}, val_q.in_dis, val_q.out_dis,
                                (val_q.in_dis ? val_q.level : pin_s)};
            SEL_DBG: rd_word = dbg_q;
            default: rd_word = '0;
        endcase
    end

    assign status  = status_q;
    assign od      = view.od;
    assign pad_oe  = !val_q.out_dis && !(view.od && val_q.level);
    assign pad_out = val_q.level && !view.od;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int                  NUM_PADS     = 28,
    parameter int                  ADDR_W       = 12,
    parameter logic [NUM_PADS-1:0] ALT_MUX_PADS = 28'h300_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic                irq
);
    localparam int NUM_BANKS = (NUM_PADS + BANK_W - 1) / BANK_W;
    localparam int PIDX_W    = ADDR_W - WIN_SHIFT;
    localparam int BIDX_W    = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_BASE);

    logic [NUM_PADS-1:0]         pin_s;
    logic [NUM_PADS-1:0]         stat_vec;
    logic [NUM_PADS-1:0]         armed_vec;
    logic [NUM_PADS-1:0]         clr_vec;
    logic [NUM_PADS-1:0]         od_vec;
    logic [WORD_W-1:0]           pad_rd [NUM_PADS];
    logic [NUM_BANKS*BANK_W-1:0] stat_padded;

    logic              in_stat;
    logic [PIDX_W-1:0] pad_idx;
    logic [ADDR_W-1:0] bank_off;
    logic [BIDX_W-1:0] bank_idx;
    regsel_e           sel;
    logic              unused_low_addr;

    assign in_stat         = bus_addr >= STAT_ADDR;
    assign pad_idx         = bus_addr[ADDR_W-1:WIN_SHIFT];
    assign bank_off        = bus_addr - STAT_ADDR;
    assign bank_idx        = bank_off[ADDR_W-1:2];
    assign sel             = regsel_e'(bus_addr[3:2]);
    assign unused_low_addr = ^bus_addr[1:0];

    gpio_sync #(.W(NUM_PADS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_s)
    );

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        localparam logic [MUX_W-1:0] MUXV = ALT_MUX_PADS[i] ? MUX_W'(1) : MUX_W'(0);
        logic wr_hit;

        assign wr_hit     = bus_we && !in_stat && (pad_idx == PIDX_W'(i));
        assign clr_vec[i] = bus_we && in_stat && (bank_idx == BIDX_W'(i / BANK_W))
                            && bus_wdata[i % BANK_W];

        gpio_pad #(.GPIO_MUX(MUXV)) u_pad (
            .clk      (clk),
            .rst      (rst),
            .wr_hit   (wr_hit),
            .sel      (sel),
            .wdata    (bus_wdata),
            .stat_clr (clr_vec[i]),
            .pin_s    (pin_s[i]),
            .rd_word  (pad_rd[i]),
            .status   (stat_vec[i]),
            .armed    (armed_vec[i]),
            .od       (od_vec[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i])
        );
    end

    for (genvar j = 0; j < NUM_BANKS * BANK_W; j++) begin : g_stat_pad
        if (j < NUM_PADS) begin : g_real
            assign stat_padded[j] = stat_vec[j];
        end else begin : g_void
            assign stat_padded[j] = 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_stat) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_idx == BIDX_W'(b))
                    bus_rdata = stat_padded[b*BANK_W +: BANK_W];
            end
        end else begin
            for (int p = 0; p < NUM_PADS; p++) begin
                if (pad_idx == PIDX_W'(p))
                    bus_rdata = pad_rd[p];
            end
        end
    end

    assign irq = |stat_vec;
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
    parameter int NUM_PADS = 28
) (
    input logic                clk,
    input logic                rst,
    input logic                irq,
    input logic [NUM_PADS-1:0] pad_out,
    input logic [NUM_PADS-1:0] pad_oe,
    input logic [NUM_PADS-1:0] stat_vec,
    input logic [NUM_PADS-1:0] armed_vec,
    input logic [NUM_PADS-1:0] clr_vec,
    input logic [NUM_PADS-1:0] od_vec
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq && (pad_oe == '0)));

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_chk
        assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
            (!armed_vec[i] && !stat_vec[i]) |=> !stat_vec[i]);

        assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
            (stat_vec[i] && !clr_vec[i]) |=> stat_vec[i]);

        assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !armed_vec[i]) |=> !stat_vec[i]);

        assert_od_low_R11: assert property (@(posedge clk) disable iff (rst)
            od_vec[i] |-> !pad_out[i]);

        assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
            stat_vec[i] |-> irq);
    end
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NUM_PADS(NUM_PADS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .stat_vec  (stat_vec),
    .armed_vec (armed_vec),
    .clr_vec   (clr_vec),
    .od_vec    (od_vec)
);

// File: tb/test_gpio_pad_ctrl.sv
module test_gpio_pad_ctrl;
    localparam int NP = 28;
    localparam logic [NP-1:0] ALT = 28'h300_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin = '0;
    logic [NP-1:0] pout;
    logic [NP-1:0] poe;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gpio_pad_ctrl #(.NUM_PADS(NP), .ADDR_W(12), .ALT_MUX_PADS(ALT)) i_gpio_pad_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .pad_in    (pin),
        .pad_out   (pout),
        .pad_oe    (poe),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic [11:0] win(input int p, input int off);
        return 12'(p * 16 + off);
    endfunction

    function automatic logic [31:0] mux_of(input int p);
        return ALT[p] ? 32'd1 : 32'd0;
    endfunction

    // trigger codes for bits [26:24]: rise, fall, both, level-high, level-low
    function automatic logic [2:0] trig_code(input int m);
        case (m)
            0: return 3'b010;
            1: return 3'b100;
            2: return 3'b110;
            3: return 3'b011;
            default: return 3'b101;
        endcase
    endfunction

    function automatic logic exp_stat(input int m, input logic b, input logic a);
        case (m)
            0: return !b && a;
            1: return b && !a;
            2: return b != a;
            3: return b || a;
            default: return !b || !a;
        endcase
    endfunction

    initial begin : watchdog
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] model [NP][4];
        void'($urandom(32'h5EED_0042));
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(win(0, 0), d);      chk("R1 cfg pad0", d, 32'h0);
        rd(win(NP-1, 4), d);   chk("R1 aux last", d, 32'h0);
        rd(win(3, 8), d);      chk("R1 val pad3", d, 32'h6);
        rd(win(NP-1, 12), d);  chk("R1 dbg last", d, 32'h0);
        rd(12'h800, d);        chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 oe", {4'b0, poe}, 32'h0);

        // R2 random register write/readback (pins held low)
        for (int p = 0; p < NP; p++) begin
            model[p][0] = 0; model[p][1] = 0; model[p][2] = 32'h6; model[p][3] = 0;
        end
        for (int k = 0; k < 48; k++) begin
            int p = $urandom_range(0, NP-1);
            int s = $urandom_range(0, 3);
            logic [31:0] v = $urandom;
            wr(win(p, s*4), v);
            model[p][s] = (s == 2) ? {29'b0, v[2:0]} : v;
            if (s == 2 && !v[2]) model[p][2][0] = 1'b0;
            rd(win(p, s*4), d);
            chk("R2 readback", d, model[p][s]);
        end
        for (int k = 0; k < 8; k++) begin
            int p = $urandom_range(0, NP-1);
            int s = $urandom_range(0, 3);
            rd(win(p, s*4), d);
            chk("R2 window isolation", d, model[p][s]);
        end
        rd(win(NP, 0), d); chk("R2 empty window", d, 32'h0);
        for (int p = 0; p < NP; p++) begin
            wr(win(p, 0), 32'h0);
            wr(win(p, 8), 32'h6);
        end
        wr(12'h800, 32'hFFFF_FFFF);
        idle(1);

        // R9 out-of-range bits read 0 and status is clear
        rd(12'h800, d); chk("R9 status after clear", d, 32'h0);

        // R3 rising edge latency on pad 3
        wr(win(3, 0), {5'b0, trig_code(0), 24'b0} | mux_of(3));
        @(negedge clk); pin[3] = 1'b1;
        idle(2); #1 chk("R3 not yet after two edges", {31'b0, irq}, 32'h0);
        idle(1); #1 chk("R3 set on third edge", {31'b0, irq}, 32'h1);
        rd(12'h800, d); chk("R9 bank bit pad3", d, 32'h8);
        wr(12'h800, 32'h0);
        rd(12'h800, d); chk("R9 zero write no effect", d, 32'h8);
        wr(12'h800, 32'h8);
        rd(12'h800, d); chk("R9 w1c", d, 32'h0);
        chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
        wr(win(3, 0), 32'h0);
        pin[3] = 1'b0;

        // R6 level high keeps re-setting while asserted
        wr(win(5, 0), {5'b0, trig_code(3), 24'b0} | mux_of(5));
        @(negedge clk); pin[5] = 1'b1;
        idle(4);
        wr(12'h800, 32'h20);
        rd(12'h800, d); chk("R6 clear ignored while high", d, 32'h20);
        @(negedge clk); pin[5] = 1'b0;
        idle(4);
        rd(12'h800, d); chk("R6 sticky after low", d, 32'h20);
        wr(12'h800, 32'h20);
        rd(12'h800, d); chk("R6 clear after low", d, 32'h0);
        wr(win(5, 0), 32'h0);

        // R8 mux mismatch and direct-route bit on alternate-mux pad 24
        wr(win(24, 0), {5'b0, trig_code(0), 24'b0});
        @(negedge clk); pin[24] = 1'b1;
        idle(4);
        rd(12'h800, d); chk("R8 wrong mux blocks", d, 32'h0);
        pin[24] = 1'b0; idle(4);
        wr(win(24, 0), 32'h0800_0000 | {5'b0, trig_code(0), 24'b0} | 32'd1);
        @(negedge clk); pin[24] = 1'b1;
        idle(4);
        rd(12'h800, d); chk("R8 direct bit blocks", d, 32'h0);
        pin[24] = 1'b0; idle(4);
        wr(win(24, 0), {5'b0, trig_code(0), 24'b0} | 32'd1);
        @(negedge clk); pin[24] = 1'b1;
        idle(4);
        rd(12'h800, d); chk("R8 alternate mux detects", d, 32'h0100_0000);
        wr(win(24, 0), 32'h0);
        wr(12'h800, 32'hFFFF_FFFF);
        pin[24] = 1'b0;
        @(negedge clk); pin[2] = 1'b1;
        idle(4); pin[2] = 1'b0; idle(4);
        rd(12'h800, d); chk("R8 masked pad silent", d, 32'h0);

        // R3 R4 R5 R6 R7 random trigger trials
        for (int k = 0; k < 30; k++) begin
            int p = $urandom_range(0, NP-1);
            int m = $urandom_range(0, 4);
            logic b = 1'($urandom_range(0, 1));
            logic a = 1'($urandom_range(0, 1));
            logic e;
            wr(win(p, 0), 32'h0);
            @(negedge clk); pin[p] = b;
            idle(4);
            wr(win(p, 0), {5'b0, trig_code(m), 24'b0} | mux_of(p));
            wr(12'h800, 32'hFFFF_FFFF);
            @(negedge clk); pin[p] = a;
            idle(4);
            e = exp_stat(m, b, a);
            rd(12'h800, d);
            chk($sformatf("R%0d trigger trial", m + 3), d, e ? (32'h1 << p) : 32'h0);
            chk("R10 irq matches status", {31'b0, irq}, {31'b0, e});
            wr(win(p, 0), 32'h0);
            wr(12'h800, 32'hFFFF_FFFF);
        end
        pin = '0;
        idle(4);
        wr(12'h800, 32'hFFFF_FFFF);

        // R11 output drive and open-drain
        wr(win(7, 8), 32'h0);
        chk("R11 drive low oe", {31'b0, poe[7]}, 32'h1);
        chk("R11 drive low out", {31'b0, pout[7]}, 32'h0);
        wr(win(7, 8), 32'h1);
        chk("R11 drive high out", {30'b0, poe[7], pout[7]}, 32'h3);
        wr(win(7, 0), 32'h8000_0000);
        chk("R11 open-drain releases high", {30'b0, poe[7], pout[7]}, 32'h0);
        wr(win(7, 8), 32'h0);
        chk("R11 open-drain drives low", {30'b0, poe[7], pout[7]}, 32'h2);
        wr(win(7, 8), 32'h3);
        chk("R11 output disabled", {30'b0, poe[7], pout[7]}, 32'h0);

        // R12 input readback
        wr(win(9, 8), 32'h0);
        @(negedge clk); pin[9] = 1'b1;
        idle(3);
        rd(win(9, 8), d); chk("R12 reads pad input", d, 32'h1);
        wr(win(9, 8), 32'h4);
        rd(win(9, 8), d); chk("R12 reads stored level", d, 32'h4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule